// File: doc/BRIEF.md
# Serial Port Interrupt Identification and Modem Status Unit

This block sits beside the receive and transmit paths of a 16550-style serial controller. It chooses which interrupt source to report to the host, drives a single interrupt request line, and tracks the four modem input lines. The controller's register decode reads two values from it: a 3-bit identification code and an 8-bit modem status byte.

The four modem inputs can change at any time, so each one passes through a two-flop synchronizer. The synchronized levels are compared with their values one cycle earlier. Clear-to-send, data-set-ready and carrier-detect latch a change flag on either edge. Ring-indicator latches its flag only when the line falls from 1 to 0. The change flags stay set until the host reads the modem status byte. The transmit-empty source is edge-armed: an identification read that reports it disarms it until the holding register becomes empty again.

Top module: `sio_irq_msr`

## Requirements
- R1: After reset, with every input low, `ms_o` is 8'h00, `id_o` is 3'b001 and `irq_o` is 0.
- R2: `irq_o` is 1 exactly when at least one enabled source is pending. `id_o[0]` is the inverse of `irq_o`, so 1 means nothing is pending.
- R3: The sources are reported with a fixed priority, highest first: line error (`id_o` = 3'b110), receive data (3'b100), transmit empty (3'b010), modem change (3'b000).
- R4: Each bit of `ie_i` enables one source: bit 0 receive data, bit 1 transmit empty, bit 2 line error, bit 3 modem change. A source whose enable bit is 0 is never reported and does not raise `irq_o`.
- R5: `ms_o[7:4]` shows the synchronized levels {dcd, ri, dsr, cts}. A change at an input appears after the second rising clock edge.
- R6: `ms_o[3]`, `ms_o[1]` and `ms_o[0]` latch any change of dcd, dsr and cts respectively. The flag becomes visible after the third rising edge following the input change.
- R7: `ms_o[2]` latches only a 1-to-0 transition of ri. A 0-to-1 transition leaves it unchanged.
- R8: A cycle with `ms_rd_i` high clears `ms_o[3:0]` at the next edge. A change detected in that same cycle is still latched.
- R9: A modem-change interrupt is pending whenever any bit of `ms_o[3:0]` is 1.
- R10: A rising edge of `thr_empty_i` arms the transmit-empty source from the next edge onward. The source is only reported while `thr_empty_i` is high. A cycle with `id_rd_i` high while `id_o` is 3'b010 disarms it until `thr_empty_i` rises again.
- R11: An identification read while another source is reported leaves the transmit-empty source armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| ri_i | input | 1 | Ring-indicator line, asynchronous |
| dcd_i | input | 1 | Carrier-detect line, asynchronous |
| line_err_i | input | 1 | Receiver line error condition pending |
| rx_avail_i | input | 1 | Received data available |
| thr_empty_i | input | 1 | Transmit holding register empty |
| ie_i | input | 4 | Interrupt enable bits |
| id_rd_i | input | 1 | Host read strobe for the identification code |
| ms_rd_i | input | 1 | Host read strobe for the modem status byte |
| id_o | output | 3 | Identification code; bit 0 is 1 when nothing is pending |
| ms_o | output | 8 | Modem status: levels in 7:4, change flags in 3:0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The results fall due at different times:
- Line error, receive data and the enable bits act on `id_o` and `irq_o` in the same cycle, with no register in between.
- Transmit-empty arming and disarming take effect one edge after the cycle that causes them.
- Modem levels show after two edges and change flags after three.

The bench drives inputs at the falling edge and compares all outputs one time step later. Its reference model advances one step per rising edge, with the same register depth stated in the requirements. Every comparison therefore falls exactly in the cycle in which the requirement says the value is due.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    localparam int N_MODEM   = 4;   // order {dcd, ri, dsr, cts}
    localparam int RI_IDX    = 2;
    localparam int N_SRC     = 4;
    localparam int IE_RXD    = 0;
    localparam int IE_THRE   = 1;
    localparam int IE_LINE   = 2;
    localparam int IE_MODEM  = 3;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'b001,
        SRC_LINE  = 3'b110,
        SRC_RXD   = 3'b100,
        SRC_THRE  = 3'b010,
        SRC_MODEM = 3'b000
    } irq_src_e;

    typedef struct packed {
        logic [N_MODEM-1:0] meta;
        logic [N_MODEM-1:0] sync;
        logic [N_MODEM-1:0] prev;
        logic [N_MODEM-1:0] delta;
    } modem_state_t;

    typedef struct packed {
        logic thr_prev;
        logic thre_pend;
    } prio_state_t;

endpackage

// File: rtl/sio_modem_track.sv
module sio_modem_track
    import sio_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_MODEM-1:0] lines_i,
    input  logic               rd_i,
    output logic [N_MODEM-1:0] level_o,
    output logic [N_MODEM-1:0] delta_o
);

    modem_state_t st_d, st_q;
    logic [N_MODEM-1:0] chg;

    always_comb begin
        st_d      = st_q;
        st_d.meta = lines_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
        chg       = st_q.sync ^ st_q.prev;
        chg[RI_IDX] = st_q.prev[RI_IDX] & ~st_q.sync[RI_IDX];
        st_d.delta = (rd_i ? '0 : st_q.delta) | chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.sync;
    assign delta_o = st_q.delta;

    // R8: a read in a cycle with no movement empties every flag
    p_rd_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (st_q.sync == st_q.prev)) |=> (delta_o == '0));

    // R6: without a read, flags never drop
    p_delta_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((delta_o & $past(delta_o)) == $past(delta_o)));

    // R7: ri flag does not move unless the previous level was 1
    p_ri_rise_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && !st_q.prev[RI_IDX]) |=> $stable(delta_o[RI_IDX]));

endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
    import sio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] ie_i,
    input  logic             line_err_i,
    input  logic             rx_avail_i,
    input  logic             thr_empty_i,
    input  logic             modem_any_i,
    input  logic             id_rd_i,
    output logic [2:0]       id_o,
    output logic             irq_o
);

    prio_state_t st_d, st_q;
    irq_src_e    src;
    logic        thr_rise, clr_thre;
    logic [N_SRC-1:0] req;

    always_comb begin
        req[IE_LINE]  = line_err_i  & ie_i[IE_LINE];
        req[IE_RXD]   = rx_avail_i  & ie_i[IE_RXD];
        req[IE_THRE]  = st_q.thre_pend & thr_empty_i & ie_i[IE_THRE];
        req[IE_MODEM] = modem_any_i & ie_i[IE_MODEM];

        if      (req[IE_LINE])  src = SRC_LINE;
        else if (req[IE_RXD])   src = SRC_RXD;
        else if (req[IE_THRE])  src = SRC_THRE;
        else if (req[IE_MODEM]) src = SRC_MODEM;
        else                    src = SRC_NONE;

        thr_rise       = thr_empty_i & ~st_q.thr_prev;
        clr_thre       = id_rd_i && (src == SRC_THRE);
        st_d           = st_q;
        st_d.thr_prev  = thr_empty_i;
        st_d.thre_pend = (st_q.thre_pend & ~clr_thre) | thr_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign id_o  = src;
    assign irq_o = |req;

    // R2: request line and pending flag always agree
    p_irq_vs_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == !id_o[0]);

    // R3: an enabled line error always wins
    p_line_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err_i && ie_i[IE_LINE]) |-> (id_o == 3'b110));

    // R10: reading while transmit-empty is reported disarms it
    p_thre_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd_i && id_o == 3'b010 && !thr_rise) |=> !st_q.thre_pend);

endmodule

// File: rtl/sio_irq_msr.sv
module sio_irq_msr
    import sio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_i,
    input  logic       dsr_i,
    input  logic       ri_i,
    input  logic       dcd_i,
    input  logic       line_err_i,
    input  logic       rx_avail_i,
    input  logic       thr_empty_i,
    input  logic [3:0] ie_i,
    input  logic       id_rd_i,
    input  logic       ms_rd_i,
    output logic [2:0] id_o,
    output logic [7:0] ms_o,
    output logic       irq_o
);

    logic [N_MODEM-1:0] lvl, dlt;

    sio_modem_track u_modem (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i ({dcd_i, ri_i, dsr_i, cts_i}),
        .rd_i    (ms_rd_i),
        .level_o (lvl),
        .delta_o (dlt)
    );

    sio_irq_prio u_prio (
        .clk         (clk),
        .rst_n       (rst_n),
        .ie_i        (ie_i),
        .line_err_i  (line_err_i),
        .rx_avail_i  (rx_avail_i),
        .thr_empty_i (thr_empty_i),
        .modem_any_i (|dlt),
        .id_rd_i     (id_rd_i),
        .id_o        (id_o),
        .irq_o       (irq_o)
    );

    assign ms_o = {lvl, dlt};

    // R9: with only modem changes enabled, any flag raises the request
    p_modem_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_i == 4'b1000 && |ms_o[3:0]) |-> (irq_o && id_o == 3'b000));

endmodule

// File: tb/tb_sio_irq_msr.sv
module tb_sio_irq_msr;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cts_i = 0, dsr_i = 0, ri_i = 0, dcd_i = 0;
    logic line_err_i = 0, rx_avail_i = 0, thr_empty_i = 0;
    logic [3:0] ie_i = 4'h0;
    logic id_rd_i = 0, ms_rd_i = 0;
    logic [2:0] id_o;
    logic [7:0] ms_o;
    logic       irq_o;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // reference state
    logic [3:0] m_s1, m_s2, m_prev, m_delta;
    logic       m_thr_prev, m_pend;
    logic [2:0] exp_id;

    always #5 clk = ~clk;

    sio_irq_msr dut (
        .clk(clk), .rst_n(rst_n), .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i),
        .dcd_i(dcd_i), .line_err_i(line_err_i), .rx_avail_i(rx_avail_i),
        .thr_empty_i(thr_empty_i), .ie_i(ie_i), .id_rd_i(id_rd_i),
        .ms_rd_i(ms_rd_i), .id_o(id_o), .ms_o(ms_o), .irq_o(irq_o)
    );

    function automatic logic [2:0] ref_id();
        if (line_err_i && ie_i[2])                   return 3'b110;
        if (rx_avail_i && ie_i[0])                   return 3'b100;
        if (m_pend && thr_empty_i && ie_i[1])        return 3'b010;
        if ((|m_delta) && ie_i[3])                   return 3'b000;
        return 3'b001;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_s1 = 0; m_s2 = 0; m_prev = 0; m_delta = 0;
        m_thr_prev = 0; m_pend = 0;
    endtask

    // compare now, then advance one edge
    task automatic step(input string tag);
        logic [3:0] chg;
        #1;
        exp_id = ref_id();
        chk({tag, " id (R2 R3 R4)"}, {29'd0, id_o}, {29'd0, exp_id});
        chk({tag, " irq (R2)"}, {31'd0, irq_o}, {31'd0, exp_id != 3'b001});
        chk({tag, " levels (R5)"}, {28'd0, ms_o[7:4]}, {28'd0, m_s2});
        chk({tag, " flags (R6 R7 R8 R9)"}, {28'd0, ms_o[3:0]}, {28'd0, m_delta});
        @(posedge clk);
        chg = m_s2 ^ m_prev;
        chg[2] = m_prev[2] & ~m_s2[2];
        m_delta = (ms_rd_i ? 4'h0 : m_delta) | chg;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = {dcd_i, ri_i, dsr_i, cts_i};
        m_pend = (m_pend & ~(id_rd_i && exp_id == 3'b010)) | (thr_empty_i & ~m_thr_prev);
        m_thr_prev = thr_empty_i;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: quiet state after reset
        chk("R1 ms", {24'd0, ms_o}, 32'h0);
        chk("R1 id", {29'd0, id_o}, 32'h1);
        chk("R1 irq", {31'd0, irq_o}, 32'h0);
        idle(2, "R1");

        // R3 R4: all sources, then peel off in priority order
        ie_i = 4'hF; line_err_i = 1; rx_avail_i = 1; thr_empty_i = 1;
        step("R3 all");
        step("R3 all armed");
        chk("R3 line top", {29'd0, id_o}, 32'h6);
        line_err_i = 0; step("R3 rx");
        rx_avail_i = 0; step("R3 thre");
        chk("R10 armed", {29'd0, id_o}, 32'h2);
        ie_i = 4'b1011; line_err_i = 1; step("R4 line masked");
        ie_i = 4'b0000; rx_avail_i = 1; step("R4 all masked");
        chk("R4 no irq", {31'd0, irq_o}, 32'h0);
        ie_i = 4'hF; line_err_i = 0; rx_avail_i = 0;

        // R11: read while rx reported keeps thre
        rx_avail_i = 1; id_rd_i = 1; step("R11 read rx");
        id_rd_i = 0; rx_avail_i = 0; step("R11 thre kept");
        chk("R11 thre kept", {29'd0, id_o}, 32'h2);
        // R10: read disarms until a new rise
        id_rd_i = 1; step("R10 read thre");
        id_rd_i = 0; step("R10 disarmed");
        chk("R10 disarmed", {31'd0, irq_o}, 32'h0);
        thr_empty_i = 0; step("R10 low");
        thr_empty_i = 1; step("R10 rise");
        step("R10 rearmed");
        chk("R10 rearmed", {29'd0, id_o}, 32'h2);
        thr_empty_i = 0; step("R10 off");

        // R5 R6: cts change
        cts_i = 1; idle(4, "R6 cts");
        chk("R6 cts flag", {31'd0, ms_o[0]}, 32'h1);
        chk("R9 modem id", {29'd0, id_o}, 32'h0);
        ms_rd_i = 1; step("R8 read"); ms_rd_i = 0; idle(2, "R8 after");
        chk("R8 cleared", {28'd0, ms_o[3:0]}, 32'h0);
        // R7: ri rise does not flag, fall does
        ri_i = 1; idle(5, "R7 rise");
        chk("R7 no flag on rise", {31'd0, ms_o[2]}, 32'h0);
        ri_i = 0; idle(5, "R7 fall");
        chk("R7 flag on fall", {31'd0, ms_o[2]}, 32'h1);
        // R8: change coincident with read is kept
        ms_rd_i = 1; step("R8 clear"); ms_rd_i = 0;
        dsr_i = 1; step("R8 s1"); step("R8 s2");
        ms_rd_i = 1; step("R8 coincide"); ms_rd_i = 0;
        step("R8 kept");
        chk("R8 kept dsr", {28'd0, ms_o[3:0]}, 32'h2);

        // random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom();
            if (r[2:0] == 0) cts_i = ~cts_i;
            if (r[5:3] == 0) dsr_i = ~dsr_i;
            if (r[8:6] == 0) ri_i  = ~ri_i;
            if (r[11:9] == 0) dcd_i = ~dcd_i;
            line_err_i  = (r[14:12] == 0);
            rx_avail_i  = (r[16:15] == 0);
            if (r[18:17] == 0) thr_empty_i = ~thr_empty_i;
            if (r[21:19] == 0) ie_i = r[25:22];
            id_rd_i = (r[27:26] == 0);
            ms_rd_i = (r[29:28] == 0);
            step("rnd");
        end
        finish_run();
    end

endmodule